// File: doc/BRIEF.md
# Burst-Addressed Synchronous SRAM Model

This block is a synthesizable behavioural model of a flow-through synchronous SRAM. Each word is 36 bits wide and is split into four 9-bit lanes. A parameter sets the address depth. Address and control inputs are registered on the rising clock edge. Read data comes combinationally from the registered location in the same cycle, with no output pipeline stage.

Either of two address-start strobes loads a new base address, but only while all three chip selects are active. A two-bit wrap-around counter then generates the low two address bits of each beat, seeded from the loaded address. The order is linear or interleaved, chosen by a static mode input. An advance input steps the counter, and holding it high extends the current beat. Writes use either per-lane enables gated by a lane-write qualifier, or a global write that forces all four lanes. A sleep input freezes all state and turns the read output off.

Top module: `burst_sram`

## Requirements
- R1: During and right after reset, no burst is active and `rvalid` is 0.
- R2: At a rising edge with `sleep` low, if either `cpu_n` or `ctl_n` is low and `sel1_n`=0, `sel2`=1, `sel3_n`=0, the base address is taken from `addr` and the beat counter is cleared to 0.
- R3: At a rising edge with `sleep` low, if either strobe is low but any chip select is inactive, the burst ends and `rvalid` stays 0 until the next load.
- R4: With `intlv`=0, the low two bits of the current location are (base[1:0] + count) mod 4.
- R5: With `intlv`=1, the low two bits of the current location are base[1:0] XOR count.
- R6: At an edge with `sleep` low and both strobes high, `adv_n`=0 increments the two-bit count, wrapping 3 to 0, and `adv_n`=1 holds it.
- R7: With `allwr_n`=1 and `lanewr_n`=0, each lane k whose `lane_n[k]` is 0 writes `wdata[9k+8:9k]` into the same bits of the current word at the edge. The other lanes are left unchanged.
- R8: With `allwr_n`=1 and either `lanewr_n`=1 or all `lane_n` high, nothing is written.
- R9: With `allwr_n`=0, all four lanes of the current word are written, whatever `lanewr_n` and `lane_n` are.
- R10: When a burst is active, `out_en_n`=0, `sleep`=0 and no lane is being written, `rvalid`=1 and `rdata` equals the stored word at the current location, in the same cycle.
- R11: While `sleep` is high, edges change no state and no memory, and `rvalid` is 0.
- R12: When `out_en_n` is 1 or a write is under way, `rvalid` is 0 and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Address loaded at a start |
| cpu_n | input | 1 | Processor-side start strobe, active low |
| ctl_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Step the burst count, active low |
| sel1_n | input | 1 | Chip select 1, active low |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| allwr_n | input | 1 | Global write of all lanes, active low |
| lanewr_n | input | 1 | Qualifier for the per-lane writes, active low |
| lane_n | input | 4 | Per-lane write enables, active low |
| out_en_n | input | 1 | Read output enable, active low |
| intlv | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Freeze state and disable the output |
| wdata | input | 36 | Write data, lane k at bits 9k+8:9k |
| rdata | output | 36 | Read data, 0 when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The bench starts bursts from all four offsets in both orders and follows each burst through its wrap. A counter that saturates, or that uses addition where XOR is required, returns a wrong word on some beat. Partial lane writes are read back lane by lane, so a design that lets a lane enable bleed into its neighbour, or ignores the global-write override, shows corrupted bytes. Start attempts with a chip select off, and strobes and writes issued during sleep, are each followed by reads. A design that loads or writes in those cycles returns data from the wrong location. Random traffic against a reference array checks the same-cycle read timing.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         addr,
  input  logic                  cpu_n,
  input  logic                  ctl_n,
  input  logic                  adv_n,
  input  logic                  sel1_n,
  input  logic                  sel2,
  input  logic                  sel3_n,
  input  logic                  allwr_n,
  input  logic                  lanewr_n,
  input  logic [LANES-1:0]      lane_n,
  input  logic                  out_en_n,
  input  logic                  intlv,
  input  logic                  sleep,
  input  logic [LANES*LW-1:0]   wdata,
  output logic [LANES*LW-1:0]   rdata,
  output logic                  rvalid
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0]    base_q;
  logic [1:0]       cnt_q;
  logic             act_q;
  logic [DW-1:0]    mem [DEPTH];
  logic [1:0]       sub;
  logic [AW-1:0]    cur;
  logic [LANES-1:0] lane_we;

  wire strobe  = ~cpu_n | ~ctl_n;
  wire chip_on = ~sel1_n & sel2 & ~sel3_n;
  wire any_we  = |lane_we;

  assign sub     = intlv ? (base_q[1:0] ^ cnt_q) : (base_q[1:0] + cnt_q);
  assign cur     = {base_q[AW-1:2], sub};
  assign lane_we = {LANES{~allwr_n}} | ({LANES{~lanewr_n}} & ~lane_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else if (!sleep) begin
      if (strobe) begin
        if (chip_on) begin
          base_q <= addr;
          cnt_q  <= '0;
          act_q  <= 1'b1;
        end else begin
          act_q  <= 1'b0;
        end
      end else if (!adv_n) begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!sleep && act_q) begin
      for (int k = 0; k < LANES; k++) begin
        if (lane_we[k]) mem[cur][k*LW +: LW] <= wdata[k*LW +: LW];
      end
    end
  end

  assign rvalid = act_q & ~out_en_n & ~sleep & ~any_we;
  assign rdata  = rvalid ? mem[cur] : '0;

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && strobe && chip_on) |=> (act_q && cnt_q == 2'd0 && base_q == $past(addr)));

  // R3
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && strobe && !chip_on) |=> !rvalid);

  // R6
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !strobe && !adv_n) |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !strobe && adv_n) |=> $stable(cnt_q));

  // R11
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(base_q) && $stable(cnt_q) && $stable(act_q)));
endmodule

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
  logic clk = 0;
  logic rst_n = 0;
  logic [5:0] addr = 0;
  logic cpu_n = 1, ctl_n = 1, adv_n = 1;
  logic sel1_n = 0, sel2 = 1, sel3_n = 0;
  logic allwr_n = 1, lanewr_n = 1;
  logic [3:0] lane_n = 4'hF;
  logic out_en_n = 0, intlv = 0, sleep = 0;
  logic [35:0] wdata = 0;
  logic [35:0] rdata;
  logic rvalid;

  always #10 clk = ~clk;

  burst_sram dut (.*);

  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R1";

  logic [35:0] ref_mem [64];
  logic [5:0] m_base = 0;
  logic [1:0] m_cnt = 0;
  logic m_act = 0;

  function automatic logic [5:0] loc(logic [5:0] b, logic [1:0] c, logic il);
    logic [1:0] s;
    s = il ? (b[1:0] ^ c) : (b[1:0] + c);
    return {b[5:2], s};
  endfunction

  function automatic logic [3:0] we_of(logic aw, logic lw, logic [3:0] ln);
    return {4{~aw}} | ({4{~lw}} & ~ln);
  endfunction

  task automatic chk(string t, logic [35:0] act, logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic tick();
    logic [5:0] c;
    logic [3:0] we;
    logic ev;
    logic st;
    #5;
    c  = loc(m_base, m_cnt, intlv);
    we = we_of(allwr_n, lanewr_n, lane_n);
    ev = m_act && !out_en_n && !sleep && (we == 0);
    chk({tag, " valid"}, {35'd0, rvalid}, {35'd0, ev});
    chk({tag, " data"}, rdata, ev ? ref_mem[c] : 36'd0);
    @(posedge clk);
    if (!sleep) begin
      if (m_act)
        for (int k = 0; k < 4; k++)
          if (we[k]) ref_mem[c][k*9 +: 9] = wdata[k*9 +: 9];
      st = !cpu_n || !ctl_n;
      if (st) begin
        if (!sel1_n && sel2 && !sel3_n) begin
          m_base = addr; m_cnt = 0; m_act = 1;
        end else m_act = 0;
      end else if (!adv_n) m_cnt = m_cnt + 2'd1;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cpu_n = 1; ctl_n = 1; adv_n = 1; allwr_n = 1; lanewr_n = 1; lane_n = 4'hF;
    sel1_n = 0; sel2 = 1; sel3_n = 0; sleep = 0; out_en_n = 0;
  endtask

  task automatic start(logic [5:0] a, bit use_cpu);
    idle(); addr = a;
    if (use_cpu) cpu_n = 0; else ctl_n = 0;
    tick();
    idle();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {35'd0, rvalid}, 36'd0);
    rst_n = 1;
    tag = "R1"; tick();

    // R9 fill memory with global writes
    tag = "R9";
    for (int b = 0; b < 16; b++) begin
      start(6'(b * 4), b[0]);
      out_en_n = 1;
      for (int i = 0; i < 4; i++) begin
        allwr_n = 0; lanewr_n = 1; lane_n = 4'($urandom); adv_n = 0;
        wdata = {$urandom, 4'($urandom)};
        tick();
      end
      idle();
    end

    // R4 / R5 bursts from every offset, both orders, plus hold (R6) and wrap
    for (int m = 0; m < 2; m++)
      for (int off = 0; off < 4; off++) begin
        intlv = m[0];
        tag = m ? "R5" : "R4";
        start(6'(8 + off), off[0]);
        intlv = m[0];
        for (int i = 0; i < 4; i++) begin adv_n = 0; tick(); end
        tag = "R6"; adv_n = 1; tick(); tick();
        adv_n = 0; tick();
      end
    intlv = 0; idle();

    // R7 partial lane writes
    tag = "R7";
    start(6'd21, 0);
    lanewr_n = 0; lane_n = 4'b1110; wdata = 36'h123456789; tick();
    lanewr_n = 0; lane_n = 4'b0101; wdata = 36'hABCDEF012; tick();
    idle(); tick(); tick();

    // R8 lane qualifier with all lanes off, and lanes on without qualifier
    tag = "R8";
    lanewr_n = 0; lane_n = 4'hF; wdata = 36'hFFFFFFFFF; tick();
    lanewr_n = 1; lane_n = 4'h0; wdata = 36'hFFFFFFFFF; tick();
    idle(); tick();

    // R3 deselect by each chip select
    tag = "R3";
    addr = 6'd40; ctl_n = 0; sel1_n = 1; tick(); idle(); tick();
    start(6'd44, 1);
    addr = 6'd50; cpu_n = 0; sel2 = 0; tick(); idle(); tick();
    start(6'd30, 0);
    addr = 6'd60; ctl_n = 0; sel3_n = 1; tick(); idle();
    allwr_n = 0; wdata = 36'h0; tick(); idle(); tick();

    // R11 sleep ignores strobes, writes and advance
    tag = "R11";
    start(6'd13, 0);
    for (int i = 0; i < 6; i++) begin
      sleep = 1; addr = 6'($urandom); cpu_n = 0; adv_n = 0; allwr_n = 0;
      wdata = {$urandom, 4'($urandom)}; tick();
    end
    idle(); tick();

    // R12 output enable
    tag = "R12";
    out_en_n = 1; tick(); out_en_n = 0; tick();

    // R10 random traffic
    tag = "R10";
    for (int i = 0; i < 4000; i++) begin
      addr     = 6'($urandom);
      cpu_n    = ($urandom % 8) != 0;
      ctl_n    = ($urandom % 8) != 0;
      adv_n    = 1'($urandom);
      sel1_n   = ($urandom % 10) == 0;
      sel2     = ($urandom % 10) != 0;
      sel3_n   = ($urandom % 10) == 0;
      allwr_n  = ($urandom % 8) != 0;
      lanewr_n = ($urandom % 4) != 0;
      lane_n   = 4'($urandom);
      out_en_n = ($urandom % 8) == 0;
      sleep    = ($urandom % 16) == 0;
      if (i % 64 == 0) intlv = 1'($urandom);
      wdata    = {$urandom, 4'($urandom)};
      tick();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule